// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides where each of the two ALU operands in the execute stage comes from. It compares the two source register numbers of the instruction in execute with the destination register of the instruction one stage ahead, in the execute/memory register. It also compares them with the destination of the instruction two stages ahead, in the memory/writeback register. When the two registers do not match, the operand comes from the register-file read data. When they do match, the newer result goes straight to the ALU input and the register file is bypassed.

A source is forwarded from a later stage only if that stage will write a register and its destination is not register 0. When both later stages target the same register, the younger result, the one in execute/memory, wins. The two operands are decided separately. The block is purely combinational and has no clock or state. Hazard stalling is handled elsewhere. A loaded value reaches this block only from the memory/writeback side, once the pipeline has inserted one bubble after the load.

Top module: `fwd_select`

## Requirements
- R1: When the source register is nonzero, equals `exm_dst` and `exm_wen` is 1, the select for that operand is 2'b10 and the operand equals `exm_result`.
- R2: When there is no execute/memory match and the source register is nonzero, equals `mwb_dst` and `mwb_wen` is 1, the select is 2'b01 and the operand equals `mwb_result`.
- R3: When neither stage matches, the select is 2'b00 and the operand equals that operand's register-file value (`rf_a_data` or `rf_b_data`).
- R4: When both stages match the same source, the execute/memory result is chosen (select 2'b10).
- R5: A stage whose write-enable is 0 is ignored, even if its destination matches.
- R6: A destination of register 0 never forwards; a source of register 0 always takes the register-file value.
- R7: Operand A (`src_a`) and operand B (`src_b`) are decided independently and may each take a different source in the same cycle.
- R8: The outputs follow the inputs with no clocked stage. A change to the selected data input shows on the operand without a clock edge.
- R9: The select code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | REG_W (5) | First source register of the instruction in execute |
| src_b | input | REG_W (5) | Second source register of the instruction in execute |
| rf_a_data | input | DATA_W (32) | Register-file value read for the first source |
| rf_b_data | input | DATA_W (32) | Register-file value read for the second source |
| exm_dst | input | REG_W (5) | Destination register held in execute/memory |
| exm_wen | input | 1 | Register-write flag held in execute/memory |
| exm_result | input | DATA_W (32) | Result held in execute/memory |
| mwb_dst | input | REG_W (5) | Destination register held in memory/writeback |
| mwb_wen | input | 1 | Register-write flag held in memory/writeback |
| mwb_result | input | DATA_W (32) | Result held in memory/writeback |
| sel_a | output | 2 | Source select for operand A (00 register file, 10 execute/memory, 01 memory/writeback) |
| sel_b | output | 2 | Source select for operand B, same encoding |
| opnd_a | output | DATA_W (32) | Selected value for operand A |
| opnd_b | output | DATA_W (32) | Selected value for operand B |

## Verification
The assertions check two things whenever the inputs change. The first is that the select code is legal. The second is that the operand value matches the source the select names, the link between the comparator and the data mux. They also check that a cleared write-enable or a register-0 destination on both stages leaves the register file selected. Priority between the two stages, independence of the two operands, and the exact match rules can be shown only by the bench. The bench compares against its own model on directed collisions and on random register numbers drawn from a small range so that matches are frequent.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
// fwd_pkg: shared select encoding for the operand bypass selector.
// Assumes a two-bit select per operand; code 2'b11 is unused.
package fwd_pkg;
    typedef enum logic [1:0] {
        FWD_RF    = 2'b00,
        FWD_MEMWB = 2'b01,
        FWD_EXMEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
`timescale 1ns/1ps
// fwd_match: compares one source register with the two later-stage
// destinations and produces that operand's select.
// Assumes register 0 is constant zero and never a forwarding target.
module fwd_match
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] exm_dst,
    input  logic             exm_wen,
    input  logic [REG_W-1:0] mwb_dst,
    input  logic             mwb_wen,
    output fwd_sel_e         sel
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic exm_hit;
    logic mwb_hit;

    // Detect a usable match against each later stage.
    always_comb begin
        exm_hit = exm_wen && (exm_dst != ZERO_REG) && (exm_dst == src);
        mwb_hit = mwb_wen && (mwb_dst != ZERO_REG) && (mwb_dst == src);
    end

    // Younger stage first, then older stage, else register file.
    always_comb begin
        if (exm_hit)      sel = FWD_EXMEM;
        else if (mwb_hit) sel = FWD_MEMWB;
        else              sel = FWD_RF;
    end
endmodule

// File: rtl/fwd_operand_mux.sv
`timescale 1ns/1ps
// fwd_operand_mux: steers one of three candidate values onto an ALU
// operand according to the select. Assumes the select is a legal code.
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_data,
    input  logic [DATA_W-1:0] exm_data,
    input  logic [DATA_W-1:0] mwb_data,
    output logic [DATA_W-1:0] opnd
);
    // Three-way selection of the operand value.
    always_comb begin
        case (sel)
            FWD_EXMEM: opnd = exm_data;
            FWD_MEMWB: opnd = mwb_data;
            default:   opnd = rf_data;
        endcase
    end
endmodule

// File: rtl/fwd_select.sv
`timescale 1ns/1ps
// fwd_select: top of the execute-stage bypass selector. One match unit
// and one mux per ALU operand, built by a generate loop.
// Assumes purely combinational use: inputs come from pipeline registers.
module fwd_select
    import fwd_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_W-1:0]  src_a,
    input  logic [REG_W-1:0]  src_b,
    input  logic [DATA_W-1:0] rf_a_data,
    input  logic [DATA_W-1:0] rf_b_data,
    input  logic [REG_W-1:0]  exm_dst,
    input  logic              exm_wen,
    input  logic [DATA_W-1:0] exm_result,
    input  logic [REG_W-1:0]  mwb_dst,
    input  logic              mwb_wen,
    input  logic [DATA_W-1:0] mwb_result,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int NUM_OPND = 2;

    logic [REG_W-1:0]  src_vec [NUM_OPND];
    logic [DATA_W-1:0] rf_vec  [NUM_OPND];
    logic [DATA_W-1:0] out_vec [NUM_OPND];
    fwd_sel_e          sel_vec [NUM_OPND];

    // Gather per-operand inputs into arrays.
    always_comb begin
        src_vec[0] = src_a;
        src_vec[1] = src_b;
        rf_vec[0]  = rf_a_data;
        rf_vec[1]  = rf_b_data;
    end

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_match #(.REG_W(REG_W)) u_match (
            .src     (src_vec[g]),
            .exm_dst (exm_dst),
            .exm_wen (exm_wen),
            .mwb_dst (mwb_dst),
            .mwb_wen (mwb_wen),
            .sel     (sel_vec[g])
        );

        fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
            .sel      (sel_vec[g]),
            .rf_data  (rf_vec[g]),
            .exm_data (exm_result),
            .mwb_data (mwb_result),
            .opnd     (out_vec[g])
        );

        // Cross-check the match unit against the data mux it drives.
        always_comb begin
            assert_legal_sel_R9: assert (sel_vec[g] != fwd_sel_e'(2'b11))
                else $error("illegal select on operand %0d", g);
            if (sel_vec[g] == FWD_EXMEM)
                assert_exm_route_R1: assert (out_vec[g] == exm_result)
                    else $error("operand %0d not execute/memory value", g);
            if (sel_vec[g] == FWD_MEMWB)
                assert_mwb_route_R2: assert (out_vec[g] == mwb_result)
                    else $error("operand %0d not memory/writeback value", g);
            if (sel_vec[g] == FWD_RF)
                assert_rf_route_R3: assert (out_vec[g] == rf_vec[g])
                    else $error("operand %0d not register-file value", g);
            if (!exm_wen && !mwb_wen)
                assert_wen_gate_R5: assert (sel_vec[g] == FWD_RF)
                    else $error("forward with both write-enables low");
            if (exm_dst == '0 && mwb_dst == '0)
                assert_zero_dst_R6: assert (sel_vec[g] == FWD_RF)
                    else $error("forward from register 0 destination");
        end
    end

    // Drive the top-level outputs.
    always_comb begin
        sel_a  = sel_vec[0];
        sel_b  = sel_vec[1];
        opnd_a = out_vec[0];
        opnd_b = out_vec[1];
    end
endmodule

// File: tb/fwd_select_bench.sv
`timescale 1ns/1ps
// fwd_select_bench: directed corners plus seeded random stimulus,
// compared against a bench-side model of the select rules.
module fwd_select_bench;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int MAX_CYC = 200000;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz pacing clock

    logic [REG_W-1:0]  src_a, src_b, exm_dst, mwb_dst;
    logic [DATA_W-1:0] rf_a_data, rf_b_data, exm_result, mwb_result;
    logic              exm_wen, mwb_wen;
    logic [1:0]        sel_a, sel_b;
    logic [DATA_W-1:0] opnd_a, opnd_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    fwd_select #(.REG_W(REG_W), .DATA_W(DATA_W)) u_fwd_select (
        .src_a(src_a), .src_b(src_b),
        .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
        .exm_dst(exm_dst), .exm_wen(exm_wen), .exm_result(exm_result),
        .mwb_dst(mwb_dst), .mwb_wen(mwb_wen), .mwb_result(mwb_result),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    // Model of the select rule from the requirements.
    function automatic logic [1:0] exp_sel(input logic [REG_W-1:0] s);
        if (exm_wen && exm_dst != 0 && exm_dst == s) return 2'b10;
        if (mwb_wen && mwb_dst != 0 && mwb_dst == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [DATA_W-1:0] exp_val(input logic [1:0] sl,
                                                  input logic [DATA_W-1:0] rf);
        case (sl)
            2'b10:   return exm_result;
            2'b01:   return mwb_result;
            default: return rf;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] sl);
        case (sl)
            2'b10:   return "R1";
            2'b01:   return "R2";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare both operands and selects against the model.
    task automatic check_all(input string req);
        logic [1:0] ea, eb;
        ea = exp_sel(src_a);
        eb = exp_sel(src_b);
        check(req == "" ? tag_of(ea) : req, {30'd0, sel_a}, {30'd0, ea});
        check(req == "" ? tag_of(ea) : req, opnd_a, exp_val(ea, rf_a_data));
        check(req == "" ? tag_of(eb) : req, {30'd0, sel_b}, {30'd0, eb});
        check(req == "" ? tag_of(eb) : req, opnd_b, exp_val(eb, rf_b_data));
        check("R9", {31'd0, (sel_a == 2'b11) || (sel_b == 2'b11)}, 32'd0);
    endtask

    task automatic drive(input logic [REG_W-1:0] sa, input logic [REG_W-1:0] sb,
                         input logic [REG_W-1:0] ed, input logic ew,
                         input logic [REG_W-1:0] md, input logic mw);
        @(posedge clk);
        src_a = sa; src_b = sb;
        exm_dst = ed; exm_wen = ew;
        mwb_dst = md; mwb_wen = mw;
        rf_a_data  = $urandom; rf_b_data  = $urandom;
        exm_result = $urandom; mwb_result = $urandom;
        @(negedge clk);
    endtask

    // Watchdog: an overrun counts as a failed check.
    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        src_a = '0; src_b = '0; exm_dst = '0; mwb_dst = '0;
        exm_wen = 1'b0; mwb_wen = 1'b0;
        rf_a_data = 32'h1111_1111; rf_b_data = 32'h2222_2222;
        exm_result = 32'h3333_3333; mwb_result = 32'h4444_4444;
        @(negedge clk);
        check_all("R3");                        // idle state
        drive(5'd3, 5'd9, 5'd3, 1'b1, 5'd7, 1'b1);
        check_all("R1");
        drive(5'd7, 5'd9, 5'd3, 1'b1, 5'd7, 1'b1);
        check_all("R2");
        drive(5'd6, 5'd6, 5'd6, 1'b1, 5'd6, 1'b1);
        check_all("R4");                        // both match, younger wins
        check("R4", {30'd0, sel_a}, 32'd2);
        drive(5'd6, 5'd6, 5'd6, 1'b0, 5'd6, 1'b0);
        check_all("R5");                        // write-enables low
        drive(5'd6, 5'd6, 5'd6, 1'b0, 5'd6, 1'b1);
        check_all("R5");                        // disabled younger skipped
        drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
        check_all("R6");                        // register 0
        check("R6", opnd_a, rf_a_data);
        drive(5'd4, 5'd8, 5'd4, 1'b1, 5'd8, 1'b1);
        check_all("R7");                        // different sources
        check("R7", {28'd0, sel_a, sel_b}, {28'd0, 2'b10, 2'b01});
        // R8: change the forwarded value with no clock edge between
        #1 exm_result = 32'hCAFE_F00D;
        #1 check("R8", opnd_a, 32'hCAFE_F00D);
        for (int i = 0; i < 400; i++) begin
            drive(REG_W'($urandom_range(0, 3)), REG_W'($urandom_range(0, 3)),
                  REG_W'($urandom_range(0, 3)), 1'($urandom),
                  REG_W'($urandom_range(0, 3)), 1'($urandom));
            check_all("");
        end
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule